// File: doc/BRIEF.md
# Two-Wire RF Control Bus Slave Engine

This block is the serial front end of a slave on a two-wire RF front-end control bus. It watches a clock line and a data line, both oversampled by the local system clock. The data line is bidirectional and appears here as an input, an output and an output enable. A transaction opens with a start pattern. A 12-bit command frame follows, made of a 4-bit slave address and an 8-bit command field, and then an odd parity bit. The engine checks the parity and compares the slave address against its own unique ID, an externally supplied group ID and the broadcast address 0000. It then carries out one of three short commands: a register write with a separate data frame, a register read, or a compact write of seven bits to register 0.

Register storage is outside the block. The engine presents an address, write data and one-cycle write and read strobes. It takes back read data and a hit flag that says whether the address is implemented. On a read the slave waits one bus park cycle, drives eight data bits and a parity bit, and then drives one more park cycle low before it lets go of the line. Protocol errors are reported as one-cycle pulses on dedicated outputs.

Top module: `rffe_slave`

## Requirements
- R1: While reset is held and after it is released with an idle bus, `sdataOe` is 0 and `regWe`, `regRe` and all five error outputs are 0.
- R2: A start pattern is `sdataIn` going from 1 to 0 while `sclk` stays low. It begins a new command frame in any state and discards any partly received frame.
- R3: Line bits are sampled at `sclk` falling edges. The command frame is SA[3:0] and then C[7:0], most significant bit first, followed by a parity bit that makes the count of ones in the 13 bits odd. C[7:5]=010 is a register write to address C[4:0]. Eight data bits follow, D7 first, then an odd parity bit. A valid write gives exactly one `regWe` pulse carrying that address and data.
- R4: C[7]=1 is a register-0 write. It gives one `regWe` pulse with `regAddr`=0 and `regWdata`={0,C[6:0]}, and no data frame is expected.
- R5: C[7:5]=011 is a register read. It gives one `regRe` pulse, and `regRdata` is taken in that same cycle. After one park cycle with the line released, the slave drives D7 to D0 and then an odd parity bit. Each bit is driven after an `sclk` rising edge, so it is stable at the following falling edge.
- R6: In the `sclk` cycle after the read parity bit, the slave drives 0. It releases `sdataOe` after that cycle's falling edge.
- R7: The unique ID is taken during reset as 1010 when `idSel` is low and 1011 when it is high. Frames addressed to the unique ID, to `groupId` or to 0000 are accepted. Frames with any other address cause no strobe, no error and no drive.
- R8: A command parity error gives one `errCmdPar` pulse, and the frame produces no register access and no drive.
- R9: A data parity error on a write gives one `errDataPar` pulse and no `regWe`.
- R10: A write to an address with `regHit`=0 gives `errWrAddr` instead of `regWe`. A read from such an address gives `errRdAddr`, no `regRe` and no drive.
- R11: A read sent to 0000 or to the group ID, when that is not also the unique ID, gives `errBcastRd`, no `regRe` and no drive.
- R12: Commands with C[7:5] equal to 000 or 001 are ignored: no strobe, no error and no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| idSel | input | 1 | Picks the low bit of the unique ID, sampled during reset |
| groupId | input | 4 | Group slave ID |
| sclk | input | 1 | Bus clock |
| sdataIn | input | 1 | Bus data as seen on the line |
| sdataOut | output | 1 | Bus data driven by the slave |
| sdataOe | output | 1 | Output enable for the bus data |
| regAddr | output | 5 | Register address |
| regWdata | output | 8 | Register write data |
| regWe | output | 1 | One-cycle register write strobe |
| regRe | output | 1 | One-cycle register read strobe |
| regRdata | input | 8 | Read data for `regAddr`, valid in the same cycle |
| regHit | input | 1 | `regAddr` is an implemented register |
| errCmdPar | output | 1 | Command parity error pulse |
| errDataPar | output | 1 | Data parity error pulse |
| errWrAddr | output | 1 | Write to an unimplemented address pulse |
| errRdAddr | output | 1 | Read from an unimplemented address pulse |
| errBcastRd | output | 1 | Read to the broadcast or group ID pulse |

## Verification
On every cycle the assertions check several local rules. No strobe is issued without `regHit`. Strobes and error pulses never overlap, and each strobe lasts one cycle. The output data and its enable change only while `sclk` is high, and the line is always released from a driven 0. The scenarios are what show the frame-level behaviour: bit order and parity on both the command and the data frames, the park cycles, address matching for the unique, group and broadcast IDs under both `idSel` settings, rejection of bad frames, and the abort of a frame by a new start pattern. Each of these depends on a whole sequence of bus edges, which no single-cycle property can capture.

// File: rtl/rffe_pkg.sv
package rffe_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_DEC, ST_WDATA, ST_WCHK, ST_WR,
    ST_RREQ, ST_RPARK, ST_RDATA, ST_RTAIL, ST_RREL
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;        // clear frame shifter and parity
    logic shIn;       // shift one sampled bit in
    logic latchAddr;  // capture register address from command
    logic latchR0;    // capture register-0 address/data from command
    logic latchData;  // capture data frame as write data
    logic loadTx;     // load read data and parity for transmit
    logic txBit;      // drive next transmit bit
    logic txPark;     // drive park low
    logic dropOe;     // release the line
  } strobe_t;

endpackage

// File: rtl/rffe_dp.sv
module rffe_dp
  import rffe_pkg::*;
#(
  parameter int SA_W = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int CMD_W = 12,
  parameter logic [SA_W-1:0] USID_BASE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idSel,
  input  logic [SA_W-1:0]   groupId,
  input  logic              sclk,
  input  logic              sdataIn,
  input  logic [DATA_W-1:0] regRdata,
  input  strobe_t           stb,
  output logic              sclkFall,
  output logic              sclkRise,
  output logic              sscSeen,
  output logic              parOk,
  output logic              saUnique,
  output logic              saGroup,
  output logic              saBcast,
  output logic [2:0]        cmdType,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              sdataOut,
  output logic              sdataOe
);
  localparam int FRAME_W = CMD_W + 1;
  localparam int C_W     = CMD_W - SA_W;

  logic              sclkQ, sclkP, sdaQ, sdaP;
  logic [FRAME_W-1:0] shiftReg;
  logic              parAcc;
  logic [SA_W-1:0]   usid;
  logic [DATA_W:0]   txReg;
  logic [CMD_W-1:0]  cmdWord;
  logic [SA_W-1:0]   slaveAddr;

  assign cmdWord   = shiftReg[FRAME_W-1:1];
  assign slaveAddr = cmdWord[CMD_W-1 -: SA_W];
  assign cmdType   = cmdWord[C_W-1 -: 3];
  assign parOk     = parAcc;
  assign saUnique  = (slaveAddr == usid);
  assign saGroup   = (slaveAddr == groupId);
  assign saBcast   = (slaveAddr == '0);
  assign sclkFall  = sclkP & ~sclkQ;
  assign sclkRise  = ~sclkP & sclkQ;
  assign sscSeen   = ~sclkP & ~sclkQ & sdaP & ~sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ    <= 1'b0;
      sclkP    <= 1'b0;
      sdaQ     <= 1'b0;
      sdaP     <= 1'b0;
      shiftReg <= '0;
      parAcc   <= 1'b0;
      usid     <= {USID_BASE[SA_W-1:1], idSel};
      txReg    <= '0;
      regAddr  <= '0;
      regWdata <= '0;
      sdataOut <= 1'b0;
      sdataOe  <= 1'b0;
    end else begin
      sclkQ <= sclk;
      sclkP <= sclkQ;
      sdaQ  <= sdataIn;
      sdaP  <= sdaQ;
      if (stb.clr) begin
        shiftReg <= '0;
        parAcc   <= 1'b0;
      end else if (stb.shIn) begin
        shiftReg <= {shiftReg[FRAME_W-2:0], sdaQ};
        parAcc   <= parAcc ^ sdaQ;
      end
      if (stb.latchAddr) regAddr <= cmdWord[ADDR_W-1:0];
      if (stb.latchR0) begin
        regAddr  <= '0;
        regWdata <= DATA_W'({1'b0, cmdWord[C_W-2:0]});
      end
      if (stb.latchData) regWdata <= shiftReg[DATA_W:1];
      if (stb.loadTx) txReg <= {regRdata, ~^regRdata};
      if (stb.txBit) begin
        sdataOut <= txReg[DATA_W];
        txReg    <= {txReg[DATA_W-1:0], 1'b0};
        sdataOe  <= 1'b1;
      end
      if (stb.txPark) begin
        sdataOut <= 1'b0;
        sdataOe  <= 1'b1;
      end
      if (stb.dropOe) sdataOe <= 1'b0;
    end
  end
endmodule

// File: rtl/rffe_ctrl.sv
module rffe_ctrl
  import rffe_pkg::*;
#(
  parameter int CMD_W = 12,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkFall,
  input  logic       sclkRise,
  input  logic       sscSeen,
  input  logic       parOk,
  input  logic       saUnique,
  input  logic       saGroup,
  input  logic       saBcast,
  input  logic [2:0] cmdType,
  input  logic       regHit,
  output strobe_t    stb,
  output logic       regWe,
  output logic       regRe,
  output logic       errCmdPar,
  output logic       errDataPar,
  output logic       errWrAddr,
  output logic       errRdAddr,
  output logic       errBcastRd
);
  localparam int FRAME_W = CMD_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  state_e           st, stNxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  always_comb begin
    stNxt      = st;
    cntNxt     = cnt;
    stb        = '0;
    regWe      = 1'b0;
    regRe      = 1'b0;
    errCmdPar  = 1'b0;
    errDataPar = 1'b0;
    errWrAddr  = 1'b0;
    errRdAddr  = 1'b0;
    errBcastRd = 1'b0;
    if (sscSeen) begin
      stNxt      = ST_CMD;
      cntNxt     = '0;
      stb.clr    = 1'b1;
      stb.dropOe = 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_CMD: if (sclkFall) begin
          stb.shIn = 1'b1;
          cntNxt   = cnt + 1'b1;
          if (cnt == CNT_W'(FRAME_W - 1)) stNxt = ST_DEC;
        end
        ST_DEC: begin
          stNxt = ST_IDLE;
          if (!parOk) errCmdPar = 1'b1;
          else if (saUnique || saGroup || saBcast) begin
            if (cmdType[2]) begin
              stb.latchR0 = 1'b1;
              stNxt       = ST_WR;
            end else if (cmdType == 3'b010) begin
              stb.latchAddr = 1'b1;
              stb.clr       = 1'b1;
              cntNxt        = '0;
              stNxt         = ST_WDATA;
            end else if (cmdType == 3'b011) begin
              if (saUnique) begin
                stb.latchAddr = 1'b1;
                stNxt         = ST_RREQ;
              end else errBcastRd = 1'b1;
            end
          end
        end
        ST_WDATA: if (sclkFall) begin
          stb.shIn = 1'b1;
          cntNxt   = cnt + 1'b1;
          if (cnt == CNT_W'(DATA_W)) stNxt = ST_WCHK;
        end
        ST_WCHK: begin
          if (!parOk) begin
            errDataPar = 1'b1;
            stNxt      = ST_IDLE;
          end else begin
            stb.latchData = 1'b1;
            stNxt         = ST_WR;
          end
        end
        ST_WR: begin
          if (regHit) regWe = 1'b1;
          else errWrAddr = 1'b1;
          stNxt = ST_IDLE;
        end
        ST_RREQ: begin
          if (regHit) begin
            regRe      = 1'b1;
            stb.loadTx = 1'b1;
            stNxt      = ST_RPARK;
          end else begin
            errRdAddr = 1'b1;
            stNxt     = ST_IDLE;
          end
        end
        ST_RPARK: if (sclkFall) begin
          cntNxt = '0;
          stNxt  = ST_RDATA;
        end
        ST_RDATA: if (sclkRise) begin
          stb.txBit = 1'b1;
          cntNxt    = cnt + 1'b1;
          if (cnt == CNT_W'(DATA_W)) stNxt = ST_RTAIL;
        end
        ST_RTAIL: if (sclkRise) begin
          stb.txPark = 1'b1;
          stNxt      = ST_RREL;
        end
        ST_RREL: if (sclkFall) begin
          stb.dropOe = 1'b1;
          stNxt      = ST_IDLE;
        end
        default: stNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      st  <= stNxt;
      cnt <= cntNxt;
    end
  end
endmodule

// File: rtl/rffe_slave.sv
module rffe_slave
  import rffe_pkg::*;
#(
  parameter int SA_W = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int CMD_W = SA_W + DATA_W,
  parameter logic [SA_W-1:0] USID_BASE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idSel,
  input  logic [SA_W-1:0]   groupId,
  input  logic              sclk,
  input  logic              sdataIn,
  output logic              sdataOut,
  output logic              sdataOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata,
  input  logic              regHit,
  output logic              errCmdPar,
  output logic              errDataPar,
  output logic              errWrAddr,
  output logic              errRdAddr,
  output logic              errBcastRd
);
  strobe_t    stb;
  logic       sclkFall, sclkRise, sscSeen, parOk;
  logic       saUnique, saGroup, saBcast;
  logic [2:0] cmdType;

  rffe_dp #(
    .SA_W(SA_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W), .USID_BASE(USID_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .idSel(idSel), .groupId(groupId),
    .sclk(sclk), .sdataIn(sdataIn), .regRdata(regRdata), .stb(stb),
    .sclkFall(sclkFall), .sclkRise(sclkRise), .sscSeen(sscSeen), .parOk(parOk),
    .saUnique(saUnique), .saGroup(saGroup), .saBcast(saBcast), .cmdType(cmdType),
    .regAddr(regAddr), .regWdata(regWdata), .sdataOut(sdataOut), .sdataOe(sdataOe)
  );

  rffe_ctrl #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkFall(sclkFall), .sclkRise(sclkRise),
    .sscSeen(sscSeen), .parOk(parOk), .saUnique(saUnique), .saGroup(saGroup),
    .saBcast(saBcast), .cmdType(cmdType), .regHit(regHit), .stb(stb),
    .regWe(regWe), .regRe(regRe), .errCmdPar(errCmdPar), .errDataPar(errDataPar),
    .errWrAddr(errWrAddr), .errRdAddr(errRdAddr), .errBcastRd(errBcastRd)
  );
endmodule

// File: rtl/rffe_slave_chk.sv
module rffe_slave_chk (
  input logic clk,
  input logic rstN,
  input logic sclk,
  input logic sdataOut,
  input logic sdataOe,
  input logic regWe,
  input logic regRe,
  input logic regHit,
  input logic errCmdPar,
  input logic errDataPar,
  input logic errWrAddr,
  input logic errRdAddr,
  input logic errBcastRd
);
  AST_WE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> regHit); // R10
  AST_RE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    regRe |-> regHit); // R10
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWe, regRe, errCmdPar, errDataPar, errWrAddr, errRdAddr, errBcastRd})); // R8
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe); // R3
  AST_RE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    regRe |=> !regRe); // R5
  AST_OUT_MOVES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdataOut) |-> sclk); // R5
  AST_OE_RISES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdataOe) |-> sclk); // R5
  AST_RELEASE_FROM_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdataOe) |-> !$past(sdataOut)); // R6
endmodule

bind rffe_slave rffe_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .sdataOut(sdataOut), .sdataOe(sdataOe),
  .regWe(regWe), .regRe(regRe), .regHit(regHit), .errCmdPar(errCmdPar),
  .errDataPar(errDataPar), .errWrAddr(errWrAddr), .errRdAddr(errRdAddr),
  .errBcastRd(errBcastRd)
);

// File: tb/sim_rffe_slave.sv
module sim_rffe_slave;
  localparam int H = 8;  // clk cycles per sclk half period
  localparam int NV = 12;
  // entry: op[26:25] (0 write, 1 read, 2 reg0 write), sa[24:21], addr[20:16], data[15:8], exp[7:0]
  localparam logic [26:0] VEC [NV] = '{
    {2'd1, 4'hA, 5'd3,  8'h00, 8'h09},
    {2'd0, 4'hA, 5'd1,  8'h3C, 8'h00},
    {2'd1, 4'hA, 5'd1,  8'h00, 8'h3C},
    {2'd0, 4'h0, 5'd2,  8'hA5, 8'h00},
    {2'd1, 4'hA, 5'd2,  8'h00, 8'hA5},
    {2'd2, 4'hA, 5'd0,  8'h55, 8'h00},
    {2'd1, 4'hA, 5'd0,  8'h00, 8'h55},
    {2'd0, 4'h6, 5'd3,  8'h0F, 8'h00},
    {2'd1, 4'hA, 5'd3,  8'h00, 8'h0F},
    {2'd0, 4'hA, 5'd28, 8'h80, 8'h00},
    {2'd1, 4'hA, 5'd28, 8'h00, 8'h80},
    {2'd1, 4'hA, 5'd2,  8'h00, 8'hA5}
  };

  logic clk = 1'b0, rstN = 1'b0, idSel = 1'b0, sclk = 1'b0, sdataIn = 1'b0;
  logic [3:0] groupId = 4'h6;
  logic sdataOut, sdataOe, regWe, regRe, regHit;
  logic errCmdPar, errDataPar, errWrAddr, errRdAddr, errBcastRd;
  logic [4:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic [7:0] mem [32];
  int checks = 0, errors = 0;
  int weCnt = 0, reCnt = 0, eCP = 0, eDP = 0, eWA = 0, eRA = 0, eBR = 0, oeCyc = 0;
  logic [4:0] lastAddr = '0;
  logic [7:0] lastData = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rffe_slave u0 (
    .clk(clk), .rstN(rstN), .idSel(idSel), .groupId(groupId), .sclk(sclk),
    .sdataIn(sdataIn), .sdataOut(sdataOut), .sdataOe(sdataOe), .regAddr(regAddr),
    .regWdata(regWdata), .regWe(regWe), .regRe(regRe), .regRdata(regRdata),
    .regHit(regHit), .errCmdPar(errCmdPar), .errDataPar(errDataPar),
    .errWrAddr(errWrAddr), .errRdAddr(errRdAddr), .errBcastRd(errBcastRd)
  );

  // register file model: addresses 0..3 and 28 are implemented
  assign regHit   = (regAddr <= 5'd3) || (regAddr == 5'd28);
  assign regRdata = mem[regAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) mem[i] <= 8'(i * 3);
    end else if (regWe && regHit) mem[regAddr] <= regWdata;
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (regWe) begin weCnt++; lastAddr <= regAddr; lastData <= regWdata; end
      if (regRe) reCnt++;
      if (errCmdPar) eCP++;
      if (errDataPar) eDP++;
      if (errWrAddr) eWA++;
      if (errRdAddr) eRA++;
      if (errBcastRd) eBR++;
      if (sdataOe) oeCyc++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clkBit(input logic b);
    sclk = 1'b1; idle(2); sdataIn = b; idle(H - 2);
    sclk = 1'b0; idle(H);
  endtask

  task automatic rdBit(output logic v, output logic oe);
    sclk = 1'b1; sdataIn = 1'b0; idle(H);
    v = sdataOut; oe = sdataOe;
    sclk = 1'b0; idle(H);
  endtask

  task automatic ssc();
    sclk = 1'b0; sdataIn = 1'b1; idle(H);
    sdataIn = 1'b0; idle(H);
  endtask

  task automatic sendCmd(input logic [3:0] sa, input logic [7:0] c, input bit badPar);
    logic [11:0] w;
    w = {sa, c};
    for (int i = 11; i >= 0; i--) clkBit(w[i]);
    clkBit((~^w) ^ badPar);
  endtask

  task automatic doWrite(input logic [3:0] sa, input logic [4:0] a, input logic [7:0] d,
                         input bit badCmd, input bit badData);
    ssc();
    sendCmd(sa, {3'b010, a}, badCmd);
    for (int i = 7; i >= 0; i--) clkBit(d[i]);
    clkBit((~^d) ^ badData);
    clkBit(1'b0);
    idle(H);
  endtask

  task automatic doReg0(input logic [3:0] sa, input logic [6:0] d);
    ssc();
    sendCmd(sa, {1'b1, d}, 1'b0);
    clkBit(1'b0);
    idle(H);
  endtask

  task automatic doRead(input logic [3:0] sa, input logic [4:0] a, output logic [7:0] d,
                        output logic par, output bit parkOk, output bit driveOk,
                        output bit tailOk);
    logic v, oe;
    ssc();
    sendCmd(sa, {3'b011, a}, 1'b0);
    rdBit(v, oe);
    parkOk = !oe;
    driveOk = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      rdBit(v, oe); d[i] = v; driveOk &= oe;
    end
    rdBit(v, oe); par = v; driveOk &= oe;
    rdBit(v, oe); tailOk = oe && !v;
    tailOk &= !sdataOe;
    idle(H);
  endtask

  task automatic doReset(input logic sel);
    rstN = 1'b0; idSel = sel; sclk = 1'b0; sdataIn = 1'b0;
    idle(5);
    rstN = 1'b1;
    idle(5);
  endtask

  initial begin
    logic [7:0] d;
    logic p;
    bit pk, dr, tl;
    int w0, r0, e0, o0;
    doReset(1'b0);
    // R1 reset state
    check(!sdataOe, "R1 oe after reset", sdataOe, 0);
    check(!regWe && !regRe, "R1 strobes after reset", {regWe, regRe}, 0);
    check({errCmdPar, errDataPar, errWrAddr, errRdAddr, errBcastRd} == '0,
          "R1 error flags after reset",
          {errCmdPar, errDataPar, errWrAddr, errRdAddr, errBcastRd}, 0);

    // vector walk: R3 writes, R4 register-0 write, R5/R6 reads, R7 broadcast/group writes
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [3:0] sa;
      logic [4:0] a;
      logic [7:0] dv, ex;
      {op, sa, a, dv, ex} = VEC[i];
      w0 = weCnt;
      if (op == 2'd0) begin
        doWrite(sa, a, dv, 1'b0, 1'b0);
        check(weCnt == w0 + 1 && lastAddr == a && lastData == dv, "R3 R7 write strobe",
              {lastAddr, lastData}, {a, dv});
      end else if (op == 2'd2) begin
        doReg0(sa, dv[6:0]);
        check(weCnt == w0 + 1 && lastAddr == 5'd0 && lastData == {1'b0, dv[6:0]},
              "R4 reg0 write", {lastAddr, lastData}, {5'd0, 1'b0, dv[6:0]});
      end else begin
        r0 = reCnt;
        doRead(sa, a, d, p, pk, dr, tl);
        check(d == ex && reCnt == r0 + 1, "R5 read data", d, ex);
        check(p == ~^ex, "R5 read parity odd", p, ~^ex);
        check(pk && dr, "R5 park then drive", {pk, dr}, 2'b11);
        check(tl, "R6 final park low then release", tl, 1);
      end
    end

    // R8 command parity error
    w0 = weCnt; e0 = eCP;
    doWrite(4'hA, 5'd1, 8'h77, 1'b1, 1'b0);
    check(eCP == e0 + 1 && weCnt == w0, "R8 cmd parity error", eCP - e0, 1);

    // R9 data parity error
    w0 = weCnt; e0 = eDP;
    doWrite(4'hA, 5'd1, 8'h77, 1'b0, 1'b1);
    check(eDP == e0 + 1 && weCnt == w0, "R9 data parity error", eDP - e0, 1);
    doRead(4'hA, 5'd1, d, p, pk, dr, tl);
    check(d == 8'h3C, "R9 register unchanged", d, 8'h3C);

    // R10 unimplemented addresses
    w0 = weCnt; e0 = eWA;
    doWrite(4'hA, 5'd10, 8'h11, 1'b0, 1'b0);
    check(eWA == e0 + 1 && weCnt == w0, "R10 write bad address", eWA - e0, 1);
    r0 = reCnt; e0 = eRA; o0 = oeCyc;
    doRead(4'hA, 5'd10, d, p, pk, dr, tl);
    check(eRA == e0 + 1 && reCnt == r0 && oeCyc == o0, "R10 read bad address",
          oeCyc - o0, 0);

    // R11 read to broadcast and group IDs
    r0 = reCnt; e0 = eBR; o0 = oeCyc;
    doRead(4'h0, 5'd1, d, p, pk, dr, tl);
    check(eBR == e0 + 1 && reCnt == r0 && oeCyc == o0, "R11 broadcast read", eBR - e0, 1);
    doRead(4'h6, 5'd1, d, p, pk, dr, tl);
    check(eBR == e0 + 2 && reCnt == r0 && oeCyc == o0, "R11 group read", eBR - e0, 2);

    // R7 foreign address: nothing at all
    w0 = weCnt; r0 = reCnt; o0 = oeCyc;
    e0 = eCP + eDP + eWA + eRA + eBR;
    doWrite(4'h3, 5'd1, 8'h99, 1'b0, 1'b0);
    doRead(4'h3, 5'd1, d, p, pk, dr, tl);
    check(weCnt == w0 && reCnt == r0 && oeCyc == o0 && eCP + eDP + eWA + eRA + eBR == e0,
          "R7 foreign slave address ignored", weCnt - w0, 0);

    // R12 other command codes ignored
    ssc(); sendCmd(4'hA, 8'b000_00001, 1'b0); clkBit(1'b0); idle(H);
    ssc(); sendCmd(4'hA, 8'b001_00001, 1'b0); clkBit(1'b0); idle(H);
    check(weCnt == w0 && reCnt == r0 && oeCyc == o0 && eCP + eDP + eWA + eRA + eBR == e0,
          "R12 other commands ignored", weCnt - w0, 0);

    // R2 start pattern aborts a partial frame
    ssc();
    for (int i = 0; i < 6; i++) clkBit(1'b1);
    sdataIn = 1'b0; idle(H);
    doWrite(4'hA, 5'd2, 8'h5E, 1'b0, 1'b0);
    check(weCnt == w0 + 1 && lastAddr == 5'd2 && lastData == 8'h5E && eCP + eDP + eWA + eRA + eBR == e0,
          "R2 abort then clean write", {lastAddr, lastData}, {5'd2, 8'h5E});

    // R7 unique ID with idSel high
    doReset(1'b1);
    check(!sdataOe && !regWe, "R1 state after second reset", sdataOe, 0);
    w0 = weCnt;
    doWrite(4'hA, 5'd1, 8'h12, 1'b0, 1'b0);
    check(weCnt == w0, "R7 old ID rejected with idSel high", weCnt - w0, 0);
    doWrite(4'hB, 5'd1, 8'h34, 1'b0, 1'b0);
    check(weCnt == w0 + 1 && lastData == 8'h34, "R7 ID 1011 accepted", lastData, 8'h34);
    doRead(4'hB, 5'd1, d, p, pk, dr, tl);
    check(d == 8'h34 && dr && tl, "R7 read via ID 1011", d, 8'h34);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule